// File: doc/BRIEF.md
# Data TLB lookup with fault recording

This block is the data-side address translation buffer of a processor's memory pipeline. It holds a set of page translations, each tagged with a virtual page number and a context number, and for every load or store it searches all of them at once. A hit returns the physical page number together with the access rights the page grants. An access that breaks the page's rules is refused and sorted into one of two classes: a privilege violation (user code touching a privileged-only page) or a write-protection violation (a store to a page without write permission). An address that matches no entry is reported as a miss.

Faults leave a trace in three registers that trap software reads later. A fault status word records who faulted and why, and it can flag that a second fault arrived before the first was serviced. A fault address word holds the faulting address. A miss tag word holds the page-aligned missing address merged with the context, ready for a refill handler. Entries are loaded through a write port that names a slot, and a small read port shows each slot's used flag.

The control is a two-state machine. `ST_IDLE` waits. A lookup request moves it to `ST_RESP` (transition *accept*), and while in `ST_RESP` a new request keeps it there (transition *chain*). With no request it returns to `ST_IDLE` (transition *drain*). Outputs are valid only in `ST_RESP`.

Top module: `dtlb_lookup`

## Requirements
- R1: The buffer has ENTRIES (default 64) slots, all compared in parallel. A slot matches when it is valid, its virtual page number equals `req_va[VA_W-1:PAGE_SHIFT]` and its context equals `req_ctx`. When several slots match, the lowest-numbered one decides the outcome.
- R2: On a permitted access the response shows `rsp_hit`, the slot's physical page on `rsp_ppn`, `rsp_can_read`=1, and `rsp_can_write` equal to the slot's writable flag.
- R3: A user access (`req_user`=1) to a slot whose privileged-only flag is set gives `rsp_fault`, whether it reads or writes. This check is made before the write check. Its fault type is 1.
- R4: Otherwise, a write (`req_write`=1) to a slot without the writable flag gives `rsp_prot`, with fault type 0.
- R5: On any fault (`rsp_fault` or `rsp_prot`), if bit 0 of the status word is already 1, the word is first replaced by the value 2 to mark an overflow.
- R6: After the step in R5, the fault ORs into the status word: bit 0 = 1, bit 2 = write flag, bit 3 = user flag, bit 7 = fault type. Hits and misses leave the status word unchanged.
- R7: On any fault, the fault address word takes the whole `req_va`. Hits and misses leave it unchanged.
- R8: On a miss, `rsp_miss` is given and the miss tag word becomes `req_va` with bits [PAGE_SHIFT-1:0] cleared, ORed with `req_ctx`. Other outcomes leave it unchanged.
- R9: A hit sets the used flag of the chosen slot. Faults do not set it. Writing a slot clears its used flag. `rd_used` shows the used flag of slot `rd_idx`.
- R10: A request sampled at one rising edge makes `rsp_valid` high for the following cycle, with exactly one of hit, miss, fault or prot set. Without a request, `rsp_valid` and all four outcome flags stay low. Back-to-back requests give back-to-back responses.
- R11: After reset, all slots are invalid with clear used flags, the three recording words are zero, and no response is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load slot `wr_idx` |
| wr_idx | input | IDX_W | Slot to load |
| wr_valid | input | 1 | Valid flag to store |
| wr_vpn | input | VA_W-PAGE_SHIFT | Virtual page number to store |
| wr_ctx | input | CTX_W | Context to store |
| wr_ppn | input | PPN_W | Physical page to store |
| wr_priv | input | 1 | Privileged-only flag to store |
| wr_writable | input | 1 | Writable flag to store |
| req | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address of the access |
| req_ctx | input | CTX_W | Current context number |
| req_user | input | 1 | 1 = user-mode access |
| req_write | input | 1 | 1 = write access |
| rd_idx | input | IDX_W | Slot whose used flag is shown |
| rd_used | output | 1 | Used flag of slot `rd_idx` |
| rsp_valid | output | 1 | Response cycle |
| rsp_hit | output | 1 | Access granted |
| rsp_miss | output | 1 | No slot matched |
| rsp_fault | output | 1 | Privilege violation |
| rsp_prot | output | 1 | Write-protection violation |
| rsp_ppn | output | PPN_W | Physical page on a hit, else 0 |
| rsp_can_read | output | 1 | Read right granted |
| rsp_can_write | output | 1 | Write right granted |
| fsr | output | FSR_W | Fault status word |
| far | output | VA_W | Fault address word |
| tag_access | output | VA_W | Miss tag word |

## Verification
The bench targets the places where a lookup is easy to get subtly wrong. A user store to a privileged read-only page must come out as a privilege fault: a design that tests writability first would report a protection fault with type bit 7 clear. A second fault before the status word is cleared must collapse it to the overflow value. A design that only ORs would keep stale user and type bits. Several slots share one page in different contexts and at different indices, so a design that ignores the context or picks the highest index returns the wrong page. The bench also follows the used flags through hits, faults and slot rewrites, and it sends back-to-back requests to catch a response that is late or dropped.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    typedef enum logic [1:0] {
        CLS_HIT  = 2'd0,
        CLS_MISS = 2'd1,
        CLS_PRIV = 2'd2,
        CLS_PROT = 2'd3
    } look_cls_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_t;

    localparam int FSR_VALID_BIT = 0;
    localparam int FSR_WRITE_BIT = 2;
    localparam int FSR_USER_BIT  = 3;
    localparam int FSR_TYPE_BIT  = 7;

endpackage

// File: rtl/dtlb_match.sv
module dtlb_match #(
    parameter  int ENTRIES = 64,
    parameter  int VPN_W   = 19,
    parameter  int CTX_W   = 13,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
    input  logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx,
    input  logic [VPN_W-1:0]              look_vpn,
    input  logic [CTX_W-1:0]              look_ctx,
    output logic                          found,
    output logic [IDX_W-1:0]              found_idx
);

    logic [ENTRIES-1:0] hit_vec;

    // one comparator per slot, all evaluated in the same cycle
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = ent_valid[g]
                              && (ent_vpn[g] == look_vpn)
                              && (ent_ctx[g] == look_ctx);
        end
    endgenerate

    // lowest index wins: scan downwards so the last assignment is the lowest
    always_comb begin
        found     = |hit_vec;
        found_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dtlb_perm.sv
module dtlb_perm
    import dtlb_pkg::*;
(
    input  logic      priv_only,
    input  logic      writable,
    input  logic      acc_user,
    input  logic      acc_write,
    output look_cls_t cls
);

    // privilege is judged before writability
    always_comb begin
        if (priv_only && acc_user) begin
            cls = CLS_PRIV;
        end else if (!writable && acc_write) begin
            cls = CLS_PROT;
        end else begin
            cls = CLS_HIT;
        end
    end

endmodule

// File: rtl/dtlb_fault_regs.sv
module dtlb_fault_regs
    import dtlb_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int CTX_W      = 13,
    parameter int FSR_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             log_fault,
    input  logic             fault_type,
    input  logic             log_miss,
    input  logic             acc_user,
    input  logic             acc_write,
    input  logic [VA_W-1:0]  acc_va,
    input  logic [CTX_W-1:0] acc_ctx,
    output logic [FSR_W-1:0] fsr_q,
    output logic [VA_W-1:0]  far_q,
    output logic [VA_W-1:0]  tag_q
);

    logic [FSR_W-1:0] fsr_base;
    logic [FSR_W-1:0] fsr_new;
    logic [VA_W-1:0]  tag_new;

    always_comb begin
        fsr_base = fsr_q[FSR_VALID_BIT] ? FSR_W'(2) : fsr_q;
        fsr_new  = fsr_base;
        fsr_new[FSR_VALID_BIT] = 1'b1;
        fsr_new[FSR_WRITE_BIT] = fsr_base[FSR_WRITE_BIT] | acc_write;
        fsr_new[FSR_USER_BIT]  = fsr_base[FSR_USER_BIT]  | acc_user;
        fsr_new[FSR_TYPE_BIT]  = fsr_base[FSR_TYPE_BIT]  | fault_type;
        tag_new = {acc_va[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}} | VA_W'(acc_ctx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_q <= '0;
            far_q <= '0;
            tag_q <= '0;
        end else begin
            if (log_fault) begin
                fsr_q <= fsr_new;
                far_q <= acc_va;
            end
            if (log_miss) begin
                tag_q <= tag_new;
            end
        end
    end

endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
    import dtlb_pkg::*;
#(
    parameter  int ENTRIES    = 64,
    parameter  int VA_W       = 32,
    parameter  int PAGE_SHIFT = 13,
    parameter  int CTX_W      = 13,
    parameter  int PPN_W      = 16,
    parameter  int FSR_W      = 16,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int VPN_W      = VA_W - PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_priv,
    input  logic             wr_writable,
    input  logic             req,
    input  logic [VA_W-1:0]  req_va,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic             req_user,
    input  logic             req_write,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_used,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic             rsp_prot,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_can_read,
    output logic             rsp_can_write,
    output logic [FSR_W-1:0] fsr,
    output logic [VA_W-1:0]  far,
    output logic [VA_W-1:0]  tag_access
);

    // slot storage
    logic [ENTRIES-1:0]            ent_valid_q;
    logic [ENTRIES-1:0]            ent_used_q;
    logic [ENTRIES-1:0]            ent_priv_q;
    logic [ENTRIES-1:0]            ent_wr_q;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn_q;
    logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn_q;

    // lookup path
    logic             found;
    logic [IDX_W-1:0] found_idx;
    look_cls_t        perm_cls;
    look_cls_t        cls_now;

    // response state
    resp_state_t      state_q, state_n;
    look_cls_t        rsp_cls_q;
    logic [PPN_W-1:0] rsp_ppn_q;
    logic             rsp_cw_q;

    dtlb_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .CTX_W   (CTX_W)
    ) u_match (
        .ent_valid (ent_valid_q),
        .ent_vpn   (ent_vpn_q),
        .ent_ctx   (ent_ctx_q),
        .look_vpn  (req_va[VA_W-1:PAGE_SHIFT]),
        .look_ctx  (req_ctx),
        .found     (found),
        .found_idx (found_idx)
    );

    dtlb_perm u_perm (
        .priv_only (ent_priv_q[found_idx]),
        .writable  (ent_wr_q[found_idx]),
        .acc_user  (req_user),
        .acc_write (req_write),
        .cls       (perm_cls)
    );

    assign cls_now = found ? perm_cls : CLS_MISS;

    dtlb_fault_regs #(
        .VA_W       (VA_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .CTX_W      (CTX_W),
        .FSR_W      (FSR_W)
    ) u_fregs (
        .clk        (clk),
        .rst_n      (rst_n),
        .log_fault  (req && ((cls_now == CLS_PRIV) || (cls_now == CLS_PROT))),
        .fault_type (cls_now == CLS_PRIV),
        .log_miss   (req && (cls_now == CLS_MISS)),
        .acc_user   (req_user),
        .acc_write  (req_write),
        .acc_va     (req_va),
        .acc_ctx    (req_ctx),
        .fsr_q      (fsr),
        .far_q      (far),
        .tag_q      (tag_access)
    );

    // flags with reset; a write to a slot overrides a same-cycle hit on it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid_q <= '0;
            ent_used_q  <= '0;
        end else begin
            if (req && (cls_now == CLS_HIT)) begin
                ent_used_q[found_idx] <= 1'b1;
            end
            if (wr_en) begin
                ent_valid_q[wr_idx] <= wr_valid;
                ent_used_q[wr_idx]  <= 1'b0;
            end
        end
    end

    // payload without reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_vpn_q[wr_idx]  <= wr_vpn;
            ent_ctx_q[wr_idx]  <= wr_ctx;
            ent_ppn_q[wr_idx]  <= wr_ppn;
            ent_priv_q[wr_idx] <= wr_priv;
            ent_wr_q[wr_idx]   <= wr_writable;
        end
    end

    assign rd_used = ent_used_q[rd_idx];

    // response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_cls_q <= CLS_MISS;
            rsp_ppn_q <= '0;
            rsp_cw_q  <= 1'b0;
        end else if (req) begin
            rsp_cls_q <= cls_now;
            rsp_ppn_q <= (cls_now == CLS_HIT) ? ent_ppn_q[found_idx] : '0;
            rsp_cw_q  <= (cls_now == CLS_HIT) && ent_wr_q[found_idx];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state: accept / chain / drain
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: state_n = req ? ST_RESP : ST_IDLE;
            ST_RESP: state_n = req ? ST_RESP : ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rsp_valid     = 1'b0;
        rsp_hit       = 1'b0;
        rsp_miss      = 1'b0;
        rsp_fault     = 1'b0;
        rsp_prot      = 1'b0;
        rsp_ppn       = '0;
        rsp_can_read  = 1'b0;
        rsp_can_write = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid     = 1'b1;
                rsp_hit       = (rsp_cls_q == CLS_HIT);
                rsp_miss      = (rsp_cls_q == CLS_MISS);
                rsp_fault     = (rsp_cls_q == CLS_PRIV);
                rsp_prot      = (rsp_cls_q == CLS_PROT);
                rsp_ppn       = rsp_ppn_q;
                rsp_can_read  = (rsp_cls_q == CLS_HIT);
                rsp_can_write = rsp_cw_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dtlb_lookup_chk.sv
module dtlb_lookup_chk #(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int CTX_W      = 13,
    parameter int FSR_W      = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic [CTX_W-1:0] req_ctx,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic             rsp_prot,
    input logic             rsp_can_read,
    input logic [FSR_W-1:0] fsr,
    input logic [VA_W-1:0]  far,
    input logic [VA_W-1:0]  tag_access
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid); // R10

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault, rsp_prot})); // R10

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_hit, rsp_miss, rsp_fault, rsp_prot} == 4'b0)); // R10

    AST_HIT_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_can_read); // R2

    AST_PRIV_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (fsr[7] && fsr[3] && fsr[0])); // R3

    AST_PROT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_prot |-> (fsr[2] && fsr[0] && !fsr[7])); // R4

    AST_FSR_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_fault || rsp_prot) && $past(fsr[0])) |-> fsr[1]); // R5

    AST_FSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_miss) |-> $stable(fsr)); // R6

    AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_miss) |-> $stable(far)); // R7

    AST_MISS_TAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (tag_access[PAGE_SHIFT-1:0] == PAGE_SHIFT'($past(req_ctx)))); // R8

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss) |-> $stable(tag_access)); // R8

endmodule

bind dtlb_lookup dtlb_lookup_chk #(
    .VA_W       (VA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .CTX_W      (CTX_W),
    .FSR_W      (FSR_W)
) u_chk (.*);

// File: tb/dtlb_lookup_tb.sv
`timescale 1ns/1ps
module dtlb_lookup_tb;

    localparam int ENTRIES    = 64;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 13;
    localparam int CTX_W      = 13;
    localparam int PPN_W      = 16;
    localparam int FSR_W      = 16;
    localparam int IDX_W      = $clog2(ENTRIES);
    localparam int VPN_W      = VA_W - PAGE_SHIFT;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en, wr_valid, wr_priv, wr_writable;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [VPN_W-1:0] wr_vpn;
    logic [CTX_W-1:0] wr_ctx, req_ctx;
    logic [PPN_W-1:0] wr_ppn, rsp_ppn;
    logic             req, req_user, req_write;
    logic [VA_W-1:0]  req_va, far, tag_access;
    logic             rd_used, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_prot;
    logic             rsp_can_read, rsp_can_write;
    logic [FSR_W-1:0] fsr;

    always #2.5 clk = ~clk;

    dtlb_lookup #(
        .ENTRIES (ENTRIES), .VA_W (VA_W), .PAGE_SHIFT (PAGE_SHIFT),
        .CTX_W (CTX_W), .PPN_W (PPN_W), .FSR_W (FSR_W)
    ) u_dut (.*);

    // reference model state, built from the requirements
    bit               m_valid [ENTRIES];
    bit               m_used  [ENTRIES];
    bit               m_priv  [ENTRIES];
    bit               m_wr    [ENTRIES];
    logic [VPN_W-1:0] m_vpn   [ENTRIES];
    logic [CTX_W-1:0] m_ctx   [ENTRIES];
    logic [PPN_W-1:0] m_ppn   [ENTRIES];
    logic [FSR_W-1:0] m_fsr = '0;
    logic [VA_W-1:0]  m_far = '0;
    logic [VA_W-1:0]  m_tag = '0;

    typedef struct {
        int               cls;   // 0 hit, 1 miss, 2 priv fault, 3 prot fault
        logic [PPN_W-1:0] ppn;
        bit               cw;
        logic [FSR_W-1:0] fsr;
        logic [VA_W-1:0]  far;
        logic [VA_W-1:0]  tag;
        string            rq;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // monitor: pops one expectation per response cycle
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10", "unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                logic [3:0] exp_oh;
                e = q.pop_front();
                exp_oh = 4'b1000 >> e.cls;
                chk({rsp_hit, rsp_miss, rsp_fault, rsp_prot} == exp_oh, e.rq, "outcome",
                    {60'd0, rsp_hit, rsp_miss, rsp_fault, rsp_prot}, {60'd0, exp_oh});
                chk(rsp_ppn == e.ppn, e.rq, "ppn", 64'(rsp_ppn), 64'(e.ppn));
                chk(rsp_can_read == (e.cls == 0), e.rq, "can_read",
                    64'(rsp_can_read), 64'(e.cls == 0));
                chk(rsp_can_write == e.cw, e.rq, "can_write", 64'(rsp_can_write), 64'(e.cw));
                chk(fsr == e.fsr, e.rq, "fsr", 64'(fsr), 64'(e.fsr));
                chk(far == e.far, e.rq, "far", 64'(far), 64'(e.far));
                chk(tag_access == e.tag, e.rq, "tag_access", 64'(tag_access), 64'(e.tag));
            end
        end
    end

    task automatic put_entry(input int idx, input bit v, input logic [VA_W-1:0] va,
                             input logic [CTX_W-1:0] ctx, input logic [PPN_W-1:0] ppn,
                             input bit priv, input bit wrok);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v;
        wr_vpn = va[VA_W-1:PAGE_SHIFT]; wr_ctx = ctx; wr_ppn = ppn;
        wr_priv = priv; wr_writable = wrok;
        m_valid[idx] = v; m_vpn[idx] = va[VA_W-1:PAGE_SHIFT]; m_ctx[idx] = ctx;
        m_ppn[idx] = ppn; m_priv[idx] = priv; m_wr[idx] = wrok; m_used[idx] = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: computes the expected outcome and queues it, then drives one request cycle
    task automatic issue(input logic [VA_W-1:0] va, input logic [CTX_W-1:0] ctx,
                         input bit user, input bit wr, input string rq);
        exp_t e;
        int   sel;
        sel = -1;
        for (int i = 0; i < ENTRIES; i++) begin
            if (sel < 0 && m_valid[i] && m_vpn[i] == va[VA_W-1:PAGE_SHIFT] && m_ctx[i] == ctx)
                sel = i;
        end
        e.ppn = '0; e.cw = 1'b0;
        if (sel < 0) begin
            e.cls = 1;
            m_tag = {va[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}} | VA_W'(ctx);
        end else if (m_priv[sel] && user) begin
            e.cls = 2;
        end else if (!m_wr[sel] && wr) begin
            e.cls = 3;
        end else begin
            e.cls = 0; e.ppn = m_ppn[sel]; e.cw = m_wr[sel]; m_used[sel] = 1'b1;
        end
        if (e.cls >= 2) begin
            if (m_fsr[0]) m_fsr = FSR_W'(2);
            m_fsr = m_fsr | FSR_W'(1) | (FSR_W'(user) << 3) | (FSR_W'(wr) << 2)
                  | ((e.cls == 2) ? FSR_W'(16'h80) : FSR_W'(0));
            m_far = va;
        end
        e.fsr = m_fsr; e.far = m_far; e.tag = m_tag; e.rq = rq;
        @(negedge clk);
        q.push_back(e);
        req = 1'b1; req_va = va; req_ctx = ctx; req_user = user; req_write = wr;
    endtask

    task automatic idle();
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic lookup(input logic [VA_W-1:0] va, input logic [CTX_W-1:0] ctx,
                          input bit user, input bit wr, input string rq);
        issue(va, ctx, user, wr, rq);
        idle();
    endtask

    task automatic check_used(input int idx, input string rq);
        @(negedge clk);
        rd_idx = IDX_W'(idx);
        #1;
        chk(rd_used == m_used[idx], rq, "used flag", 64'(rd_used), 64'(m_used[idx]));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", "run did not finish", 64'd0, 64'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_vpn = '0;
        wr_ctx = '0; wr_ppn = '0; wr_priv = 1'b0; wr_writable = 1'b0;
        req = 1'b0; req_va = '0; req_ctx = '0; req_user = 1'b0; req_write = 1'b0;
        rd_idx = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(rsp_valid == 1'b0, "R11", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk(fsr == '0, "R11", "fsr", 64'(fsr), 64'd0);
        chk(far == '0, "R11", "far", 64'(far), 64'd0);
        chk(tag_access == '0, "R11", "tag_access", 64'(tag_access), 64'd0);
        chk(rd_used == 1'b0, "R11", "used", 64'(rd_used), 64'd0);
        rst_n = 1'b1;

        // R8/R11: empty buffer misses; low offset bits cleared in the tag word
        lookup(32'h1234_5678, 13'h005, 1'b0, 1'b0, "R8");

        // R2: writable user page
        put_entry(3, 1'b1, 32'h0040_2000, 13'h007, 16'h0011, 1'b0, 1'b1);
        lookup(32'h0040_2abc, 13'h007, 1'b1, 1'b1, "R2");
        check_used(3, "R9");

        // R1: same page in other context at slot 2, duplicate at slot 10
        put_entry(2, 1'b1, 32'h0040_2000, 13'h008, 16'h00aa, 1'b0, 1'b0);
        put_entry(10, 1'b1, 32'h0040_2000, 13'h007, 16'h0022, 1'b0, 1'b1);
        lookup(32'h0040_2004, 13'h007, 1'b0, 1'b0, "R1");
        lookup(32'h0040_2004, 13'h008, 1'b0, 1'b0, "R1");
        lookup(32'h0040_2004, 13'h009, 1'b0, 1'b0, "R8");

        // R3: user write to privileged read-only page -> privilege fault first
        put_entry(5, 1'b1, 32'h0080_0000, 13'h007, 16'h0055, 1'b1, 1'b0);
        lookup(32'h0080_0123, 13'h007, 1'b1, 1'b1, "R3");
        check_used(5, "R9");
        // R4 + R5: privileged write -> protection fault with overflow
        lookup(32'h0080_0456, 13'h007, 1'b0, 1'b1, "R5");
        // R2: privileged read is granted, no write right; R6/R7 hold
        lookup(32'h0080_0789, 13'h007, 1'b0, 1'b0, "R7");
        check_used(5, "R9");

        // R9: rewriting a slot clears its used flag
        put_entry(3, 1'b1, 32'h0040_2000, 13'h007, 16'h0033, 1'b0, 1'b1);
        check_used(3, "R9");
        // R1: invalidate slot 3, slot 10 now answers
        put_entry(3, 1'b0, 32'h0040_2000, 13'h007, 16'h0033, 1'b0, 1'b1);
        lookup(32'h0040_2000, 13'h007, 1'b0, 1'b1, "R1");

        // R1: highest slot
        put_entry(63, 1'b1, 32'hfff0_0000, 13'h1fff, 16'hbeef, 1'b0, 1'b1);
        lookup(32'hfff0_1fff, 13'h1fff, 1'b1, 1'b0, "R1");
        check_used(63, "R9");

        // R10: back-to-back requests, mixed outcomes
        issue(32'h0040_2000, 13'h007, 1'b0, 1'b0, "R10");
        issue(32'h0080_0000, 13'h007, 1'b1, 1'b0, "R10");
        issue(32'h7777_0000, 13'h011, 1'b0, 1'b0, "R10");
        issue(32'h0080_0000, 13'h007, 1'b0, 1'b1, "R10");
        idle();

        // R10: no response without a request
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "idle rsp_valid", 64'(rsp_valid), 64'd0);
        chk(q.size() == 0, "R10", "pending responses", 64'(q.size()), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule